// File: doc/BRIEF.md
# Undefined-Length Burst End Predictor

This block sits beside a bus slave port and watches the beats of incrementing bursts whose length is not known in advance. Such a burst could otherwise hold the slave for as long as its master wishes. The predictor counts the accepted beats and raises a predicted-end flag on a programmable beat boundary. The slave's arbiter can treat that flag as an end of burst and re-arbitrate there.

A 3-bit code selects the window length. One setting disables prediction. The others place a boundary after every beat, or after every 4, 8, 16, 32, 64 or 128 beats. The flag is combinational from the current beat and the registered count. It is therefore high in the same cycle as the beat that completes the window.

The beat stream follows valid/ready rules. A beat is offered whenever the transfer type is non-sequential or sequential, and it is accepted only in a cycle where `beat_ready` is high. While ready is low, the master must hold the beat. The predictor does not count a held beat and does not flag it.

Top module: `burst_end_predictor`

## Requirements
- R1: After reset the beat count is zero, and no predicted end is raised until beats are accepted.
- R2: The window code maps as follows: 0 = unlimited, 1 = every beat, 2 = 4, 3 = 8, 4 = 16, 5 = 32, 6 = 64, 7 = 128 beats.
- R3: With code 0, `pred_end` never goes high, however long the burst runs.
- R4: With code 1, every accepted beat of an undefined-length burst raises `pred_end` in that same cycle.
- R5: With an N-beat code, `pred_end` is high in the cycle of accepted beat N, 2N, 3N and so on of the burst. It is one cycle wide, and counting restarts after it.
- R6: An accepted non-sequential beat (xfer_type 2'b10) starts a new burst and counts as beat 1, even in the middle of a window.
- R7: In a cycle with `beat_ready` low, no beat is counted and `pred_end` stays low. The count is kept.
- R8: An idle cycle (xfer_type 2'b00) clears the count in any cycle, and no predicted end is raised.
- R9: An accepted beat with `undef_incr` low (a fixed-length burst) never raises `pred_end` and clears the count.
- R10: A pause cycle (xfer_type 2'b01) neither counts nor clears, and raises no flag. The sequential code is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_code | input | 3 | Window length code (see R2) |
| xfer_type | input | 2 | 00 idle, 01 pause, 10 non-sequential, 11 sequential |
| undef_incr | input | 1 | Current burst is an undefined-length incrementing burst |
| beat_ready | input | 1 | Slave accepts the offered beat this cycle |
| pred_end | output | 1 | Predicted end of burst, aligned with the boundary beat |

## Verification
The assertions assume that `win_code` changes only while the port is idle, so that a window is never measured against two lengths. They also assume the inputs are known in every cycle after reset. The stimulus changes the code only after an idle cycle. Apart from that, it drives random mixes of ready stalls, pauses, idles, restarts and fixed-length beats, and a reference model checks the output every cycle.

// File: rtl/bep_pkg.sv
package bep_pkg;
  localparam int MODE_W = 3;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int MAX_LOG = NUM_MODES - 1;
  localparam int CNT_W = MAX_LOG + 1;

  typedef enum logic [1:0] {
    TR_IDLE  = 2'b00,
    TR_PAUSE = 2'b01,
    TR_NSEQ  = 2'b10,
    TR_SEQ   = 2'b11
  } xfer_e;
endpackage

// File: rtl/bep_limit_dec.sv
module bep_limit_dec
  import bep_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int CW = CNT_W
) (
  input  logic [MW-1:0] code,
  output logic [CW-1:0] limit
);
  localparam int N = 1 << MW;
  logic [CW-1:0] tbl [N];

  // code 0: no boundary, code 1: every beat, code k>=2: 2**k beats
  for (genvar g = 0; g < N; g++) begin : g_tbl
    if (g == 0) begin : g_off
      assign tbl[g] = '0;
    end else if (g == 1) begin : g_one
      assign tbl[g] = CW'(1);
    end else begin : g_pow
      assign tbl[g] = CW'(1) << g;
    end
  end

  assign limit = tbl[code];
endmodule

// File: rtl/bep_beat_qual.sv
module bep_beat_qual
  import bep_pkg::*;
(
  input  logic [1:0] xfer_type,
  input  logic       undef_incr,
  input  logic       beat_ready,
  output logic       accept,
  output logic       start,
  output logic       clear
);
  logic offered;

  always_comb begin
    offered = (xfer_type == TR_NSEQ) || (xfer_type == TR_SEQ);
    accept  = offered && beat_ready && undef_incr;
    start   = xfer_type == TR_NSEQ;
    clear   = (xfer_type == TR_IDLE) || (offered && beat_ready && !undef_incr);
  end
endmodule

// File: rtl/bep_beat_cnt.sv
module bep_beat_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          start,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          hit,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] nxt;

  always_comb begin
    nxt = start ? CW'(1) : cnt + CW'(1);
    hit = accept && (limit != '0) && (nxt >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (accept) cnt <= hit ? '0 : nxt;
  end
endmodule

// File: rtl/burst_end_predictor.sv
module burst_end_predictor
  import bep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] win_code,
  input  logic [1:0]        xfer_type,
  input  logic              undef_incr,
  input  logic              beat_ready,
  output logic              pred_end
);
  logic             accept, start, clear;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] beat_cnt;

  bep_limit_dec #(.MW(MODE_W), .CW(CNT_W)) u_dec (
    .code  (win_code),
    .limit (limit)
  );

  bep_beat_qual u_qual (
    .xfer_type  (xfer_type),
    .undef_incr (undef_incr),
    .beat_ready (beat_ready),
    .accept     (accept),
    .start      (start),
    .clear      (clear)
  );

  bep_beat_cnt #(.CW(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .start  (start),
    .clear  (clear),
    .limit  (limit),
    .hit    (pred_end),
    .cnt    (beat_cnt)
  );
endmodule

// File: rtl/bep_checker.sv
module bep_checker
  import bep_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] win_code,
  input logic [1:0]        xfer_type,
  input logic              undef_incr,
  input logic              beat_ready,
  input logic              pred_end,
  input logic [CNT_W-1:0]  cnt
);
  // R3
  unlimited_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_code == 3'd0) |-> !pred_end);
  // R4
  every_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_code == 3'd1 && beat_ready && xfer_type[1] && undef_incr) |-> pred_end);
  // R7
  stall_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ready |-> !pred_end);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_ready && xfer_type[1]) |=> (cnt == $past(cnt)));
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_type == TR_IDLE) |=> (cnt == '0));
  // R9
  fixed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !undef_incr |-> !pred_end);
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_end |=> (cnt == '0));
  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_type == TR_PAUSE) |=> (cnt == $past(cnt)));
endmodule

bind burst_end_predictor bep_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .win_code   (win_code),
  .xfer_type  (xfer_type),
  .undef_incr (undef_incr),
  .beat_ready (beat_ready),
  .pred_end   (pred_end),
  .cnt        (beat_cnt)
);

// File: tb/burst_end_predictor_bench.sv
module burst_end_predictor_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] win_code = 3'd0;
  logic [1:0] xfer_type = 2'b00;
  logic       undef_incr = 1'b0;
  logic       beat_ready = 1'b0;
  logic       pred_end;

  int checks = 0;
  int fails = 0;
  int mcnt = 0;
  int pulses = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_end_predictor u_burst_end_predictor (
    .clk(clk), .rst_n(rst_n), .win_code(win_code), .xfer_type(xfer_type),
    .undef_incr(undef_incr), .beat_ready(beat_ready), .pred_end(pred_end)
  );

  function automatic int lim_of(int c);
    if (c == 0) return 0;
    if (c == 1) return 1;
    return 1 << c;
  endfunction

  function automatic bit model_exp();
    int nb;
    if (!(beat_ready && xfer_type[1] && undef_incr)) return 1'b0;
    nb = (xfer_type == 2'b10) ? 1 : (mcnt + 1) % 256;
    return (lim_of(win_code) != 0) && (nb >= lim_of(win_code));
  endfunction

  function automatic void model_step();
    int nb;
    if (xfer_type == 2'b00) mcnt = 0;
    else if (xfer_type[1] && beat_ready) begin
      if (!undef_incr) mcnt = 0;
      else begin
        nb = (xfer_type == 2'b10) ? 1 : (mcnt + 1) % 256;
        if (lim_of(win_code) != 0 && nb >= lim_of(win_code)) mcnt = 0;
        else mcnt = nb;
      end
    end
  endfunction

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // drive at negedge, compare shortly after, advance model at posedge
  task automatic beat(input logic [1:0] t, input logic u, input logic r);
    bit e;
    @(negedge clk);
    xfer_type = t; undef_incr = u; beat_ready = r;
    #1;
    e = model_exp();
    checks++;
    if (pred_end !== e) begin
      fails++;
      $display("FAIL %s: pred_end=%b expected=%b (code %0d type %b)",
               tag, pred_end, e, win_code, t);
    end
    if (pred_end === 1'b1) pulses++;
    @(posedge clk);
    model_step();
  endtask

  task automatic set_code(input int c);
    beat(2'b00, 1'b0, 1'b1);
    @(negedge clk);
    win_code = 3'(c);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (pred_end !== 1'b0) begin
      fails++; $display("FAIL R1: pred_end=%b expected=0 in reset", pred_end);
    end
    @(negedge clk); rst_n = 1'b1;
    tag = "R1";
    beat(2'b11, 1'b1, 1'b1);

    // R2 R3 R4 R5: long bursts for every code
    for (int c = 0; c < 8; c++) begin
      set_code(c);
      tag = (c == 0) ? "R3" : (c == 1) ? "R4" : "R5";
      pulses = 0;
      beat(2'b10, 1'b1, 1'b1);
      for (int i = 1; i < 300; i++) beat(2'b11, 1'b1, 1'b1);
      checks++;
      if (pulses != ((c == 0) ? 0 : 300 / lim_of(c))) begin
        fails++;
        $display("FAIL R2: code %0d pulses=%0d expected=%0d", c, pulses,
                 (c == 0) ? 0 : 300 / lim_of(c));
      end
    end

    // R6: restart in the middle of a 4-beat window
    set_code(2); tag = "R6";
    beat(2'b10, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);
    beat(2'b10, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);
    beat(2'b11, 1'b1, 1'b1);

    // R7: stall on the boundary beat
    tag = "R7";
    beat(2'b10, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);
    beat(2'b11, 1'b1, 1'b0); beat(2'b11, 1'b1, 1'b0); beat(2'b11, 1'b1, 1'b1);

    // R8: idle abandons window
    tag = "R8";
    beat(2'b10, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);
    beat(2'b00, 1'b0, 1'b0); beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);

    // R9: fixed-length beats
    tag = "R9";
    beat(2'b10, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);
    beat(2'b11, 1'b0, 1'b1); beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);

    // R10: pause keeps count
    tag = "R10";
    beat(2'b10, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1); beat(2'b01, 1'b1, 1'b1);
    beat(2'b11, 1'b1, 1'b1); beat(2'b11, 1'b1, 1'b1);

    // mixed random traffic for every code
    for (int c = 0; c < 8; c++) begin
      set_code(c);
      tag = "R5";
      for (int i = 0; i < 1500; i++) begin
        int p;
        logic [1:0] t;
        p = $urandom_range(0, 99);
        t = (p < 3) ? 2'b00 : (p < 8) ? 2'b01 : (p < 12) ? 2'b10 : 2'b11;
        beat(t, ($urandom_range(0, 49) != 0), ($urandom_range(0, 4) != 0));
      end
    end

    finish_run();
  end
endmodule